// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one timer channel that drives a pulse-width-modulated pin. A 16-bit up-counter advances on ticks from a prescaler that divides the clock by a power of four. Two compare registers shape the waveform. Each period starts at the inactive level. The pin turns active once the counter reaches the duty value and drops back as the counter reaches the period value, where it wraps to zero.

Software programs the channel through a plain write port. There are four words: a control word, the count, the duty value and the period value. A dedicated run input starts and stops counting. Output gating is independent of the run input. It can close either at once (abrupt shutdown) or at the next period wrap.

Two one-cycle flags report the period match and the duty match, so that a neighbouring controller can react to them.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset all four registers hold zero, and `pwm_out`, `period_hit` and `duty_hit` are low.
- R2: A write with `wr_en` high takes effect at the clock edge. Address 0 is control: bits [2:0] select the prescaler, bit 3 enables the output, bit 4 makes the output active-low and bit 5 selects abrupt shutdown. Address 1 is the count, address 2 is the duty value and address 3 is the period value.
- R3: Prescaler code n (0 to 5) produces one counter tick every 4^n clocks while `cnt_en` is high. Codes 6 and 7 produce no ticks.
- R4: On a tick the counter increments. When the count equals the period value it wraps to zero instead, and `period_hit` is high for exactly the following cycle.
- R5: `duty_hit` is high for exactly the cycle after a tick on which the count equals the duty value.
- R6: While gated on, the pin is active when duty <= count < period and inactive otherwise. A duty value equal to or above the period value never makes it active.
- R7: The active-low bit inverts the pin, including its idle level, with immediate effect.
- R8: While `cnt_en` is low the count holds and no flags pulse. The prescaler restarts from zero when counting resumes.
- R9: With abrupt shutdown set, clearing the output enable puts the pin at its idle level from the cycle after the write.
- R10: With abrupt shutdown clear, clearing the output enable leaves the waveform running until the tick that wraps the counter. The pin is idle from then on.
- R11: A count write takes priority over a tick in the same cycle and loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 ctrl, 1 count, 2 duty, 3 period) |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Counter run enable |
| pwm_out | output | 1 | PWM pin level |
| period_hit | output | 1 | One-cycle period-match flag |
| duty_hit | output | 1 | One-cycle duty-match flag |

## Verification
The hardest case to reach from the ports is an output-enable clear without abrupt shutdown while the pin is active mid-period. The gate must stay open until the exact wrapping tick, even when the prescaler, the compare values or the count are rewritten in between. The random phase keeps periods short and prescaler codes mostly small, so that wraps come often. It scatters control, compare and count writes so that disables land at every phase of the period. Directed sequences then place a disable deliberately inside the active window, once in each shutdown mode.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_DUTY   = 2'd2,
    REG_PERIOD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       abrupt;
    logic       act_low;
    logic       out_en;
    logic [2:0] psel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 2 * MAX_CODE;

  logic [DIV_W-1:0] div_q, div_d, limit;
  logic             sel_ok;

  always_comb begin
    sel_ok = (int'(sel) <= MAX_CODE);
    limit  = sel_ok ? ((DIV_W'(1) << (2 * int'(sel))) - DIV_W'(1)) : '0;
    tick   = run && sel_ok && (div_q >= limit);
    if (!run || !sel_ok || tick) div_d = '0;
    else                         div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R8
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0));

  // R3
  bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) > MAX_CODE) |-> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             period_hit,
  output logic             duty_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d, dh_q, dh_d;

  always_comb begin
    wrap = tick && (cnt_q == period);
    ph_d = wrap;
    dh_d = tick && (cnt_q == duty);
    if (load)      cnt_d = load_val;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      dh_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      dh_q  <= dh_d;
    end
  end

  assign count      = cnt_q;
  assign period_hit = ph_q;
  assign duty_hit   = dh_q;

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cnt_q == period)) |=> (cnt_q == '0) && period_hit);

  // R5
  duty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q == duty)) |=> duty_hit);

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q) && !period_hit && !duty_hit);

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_en,
  input  logic             abrupt,
  input  logic             act_low,
  input  logic             wrap,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic             pin
);
  logic gate_q, gate_d, in_window, drive;

  always_comb begin
    if (out_en)               gate_d = 1'b1;
    else if (abrupt || wrap)  gate_d = 1'b0;
    else                      gate_d = gate_q;
    in_window = (count >= duty) && (count < period);
    drive     = gate_q && (out_en || !abrupt) && in_window;
    pin       = drive ^ act_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  // R10
  gate_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !out_en && !abrupt && !wrap) |=> gate_q);

  // R9
  abrupt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && abrupt) |=> !gate_q);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int CNT_W    = 16,
  parameter int MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_en,
  output logic             pwm_out,
  output logic             period_hit,
  output logic             duty_hit
);
  import pwm_chan_pkg::*;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] duty_q, duty_d, per_q, per_d, count;
  logic             tick, wrap, load;

  always_comb begin
    ctrl_d = ctrl_q;
    duty_d = duty_q;
    per_d  = per_q;
    load   = 1'b0;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_addr))
        REG_CTRL:   ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        REG_COUNT:  load   = 1'b1;
        REG_DUTY:   duty_d = wr_data;
        REG_PERIOD: per_d  = wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      duty_q <= duty_d;
      per_q  <= per_d;
    end
  end

  pwm_prescaler #(.SEL_W(3), .MAX_CODE(MAX_CODE)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(cnt_en), .sel(ctrl_q.psel), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(wr_data),
    .duty(duty_q), .period(per_q), .count(count), .wrap(wrap),
    .period_hit(period_hit), .duty_hit(duty_hit)
  );

  pwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .out_en(ctrl_q.out_en), .abrupt(ctrl_q.abrupt),
    .act_low(ctrl_q.act_low), .wrap(wrap), .count(count), .duty(duty_q),
    .period(per_q), .pin(pwm_out)
  );

  // R6
  no_window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q >= per_q) |-> (pwm_out == ctrl_q.act_low));

  // R2
  duty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (duty_q == $past(wr_data)));

  // R7
  polarity_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.out_en && ctrl_q.abrupt) |=> (pwm_out == ctrl_q.act_low));

endmodule

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cnt_en = 1'b0;
  logic        pwm_out, period_hit, duty_hit;

  int errs = 0;
  int checks = 0;
  logic model_on = 1'b0;
  string cur_req = "R4";

  always #4 clk = ~clk;

  pwm_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .pwm_out(pwm_out),
    .period_hit(period_hit), .duty_hit(duty_hit)
  );

  // reference built from the requirements
  logic [5:0]  m_ctrl;
  logic [15:0] m_cnt, m_duty, m_per;
  int          m_div;
  logic        m_gate, m_ph, m_dh;

  function automatic int lim_of(logic [2:0] code);
    if (code > 3'd5) return -1;
    return (1 << (2 * int'(code))) - 1;
  endfunction

  function automatic logic exp_pin();
    logic win;
    win = (m_cnt >= m_duty) && (m_cnt < m_per);
    return (m_gate && (m_ctrl[3] || !m_ctrl[5]) && win) ^ m_ctrl[4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_cnt <= '0; m_duty <= '0; m_per <= '0;
      m_div <= 0; m_gate <= 1'b0; m_ph <= 1'b0; m_dh <= 1'b0;
    end else begin
      int  lim;
      logic tk, wr_cnt;
      lim = lim_of(m_ctrl[2:0]);
      tk  = cnt_en && (lim >= 0) && (m_div >= lim);
      wr_cnt = wr_en && (wr_addr == 2'd1);
      m_div <= (!cnt_en || lim < 0 || tk) ? 0 : m_div + 1;
      m_ph <= tk && (m_cnt == m_per);
      m_dh <= tk && (m_cnt == m_duty);
      if (wr_cnt) m_cnt <= wr_data;
      else if (tk) m_cnt <= (m_cnt == m_per) ? 16'd0 : m_cnt + 16'd1;
      if (m_ctrl[3]) m_gate <= 1'b1;
      else if (m_ctrl[5] || (tk && m_cnt == m_per)) m_gate <= 1'b0;
      if (wr_en && wr_addr == 2'd0) m_ctrl <= wr_data[5:0];
      if (wr_en && wr_addr == 2'd2) m_duty <= wr_data;
      if (wr_en && wr_addr == 2'd3) m_per <= wr_data;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(cur_req, pwm_out, exp_pin(), "pwm_out");
      chk(cur_req, period_hit, m_ph, "period_hit");
      chk(cur_req, duty_hit, m_dh, "duty_hit");
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int gap, last, seen;
    void'($urandom(32'd20240611));
    idle(3);
    // R1 reset state
    chk("R1", pwm_out, 1'b0, "pwm_out in reset");
    chk("R1", period_hit, 1'b0, "period_hit in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1", pwm_out, 1'b0, "pwm_out after reset");
    chk("R1", duty_hit, 1'b0, "duty_hit after reset");
    model_on = 1'b1;

    // R3 ratio 4: period 3 -> period_hit every 16 clocks
    cur_req = "R3";
    wr(2'd3, 16'd3); wr(2'd2, 16'd1); wr(2'd0, 16'h0009); wr(2'd1, 16'd0);
    cnt_en = 1'b1;
    last = -1; gap = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (period_hit) begin
        if (last >= 0) gap = i - last;
        last = i;
      end
    end
    chk("R3", gap == 16, 1'b1, "period_hit spacing of 16 at code 1");

    // R3 unsupported code: no ticks even with period 0
    wr(2'd3, 16'd0); wr(2'd0, 16'h0006);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (period_hit || duty_hit) seen++; end
    chk("R3", seen == 0, 1'b1, "no flags with code 6");

    // R8 run enable low: no flags at code 0 with period 0
    cur_req = "R8";
    wr(2'd0, 16'h0000); idle(4);
    cnt_en = 1'b0; idle(1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (period_hit) seen++; end
    chk("R8", seen == 0, 1'b1, "no period_hit while stopped");
    cnt_en = 1'b1;

    // R6 duty above period keeps pin idle
    cur_req = "R6";
    wr(2'd3, 16'd5); wr(2'd2, 16'd9); wr(2'd0, 16'h0008); wr(2'd1, 16'd0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out) seen++; end
    chk("R6", seen == 0, 1'b1, "pin never active when duty>period");
    // R7 inverted idle
    cur_req = "R7";
    wr(2'd0, 16'h0018);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!pwm_out) seen++; end
    chk("R7", seen == 0, 1'b1, "inverted pin idles high");

    // R9 abrupt shutdown inside the active window
    cur_req = "R9";
    wr(2'd0, 16'h0028); wr(2'd3, 16'd40); wr(2'd2, 16'd0); wr(2'd1, 16'd2);
    idle(2);
    chk("R6", pwm_out, 1'b1, "pin active inside window");
    wr(2'd0, 16'h0020);
    chk("R9", pwm_out, 1'b0, "pin idle right after abrupt disable");

    // R10 non-abrupt shutdown waits for the wrap
    cur_req = "R10";
    wr(2'd0, 16'h0008); wr(2'd3, 16'd20); wr(2'd2, 16'd0); wr(2'd1, 16'd2);
    idle(2);
    wr(2'd0, 16'h0000);
    chk("R10", pwm_out, 1'b1, "pin still active after graceful disable");
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out) seen++; end
    chk("R10", (seen > 0) && (pwm_out == 1'b0), 1'b1, "pin idles after the wrap");

    // R11 count write, then R4/R5/R2 under random stimulus
    cur_req = "R11";
    wr(2'd0, 16'h0008); wr(2'd3, 16'd100); wr(2'd2, 16'd50); wr(2'd1, 16'd49);
    idle(4);

    cur_req = "R4";
    for (int i = 0; i < 6000; i++) begin
      int r;
      @(negedge clk);
      wr_en = 1'b0;
      r = $urandom % 100;
      if (r < 3) begin
        int p;
        logic [2:0] ps;
        p = $urandom % 10;
        ps = (p < 6) ? 3'd0 : (p < 8) ? 3'd1 : (p < 9) ? 3'd2 : 3'($urandom % 8);
        wr_en = 1'b1; wr_addr = 2'd0;
        wr_data = {10'd0, 3'($urandom % 8), ps};
      end else if (r < 6) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'($urandom % 32);
      end else if (r < 9) begin
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'($urandom % 32);
      end else if (r < 10) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'($urandom % 40);
      end else if (r < 11) begin
        cnt_en = ~cnt_en;
      end
    end
    wr_en = 1'b0;
    idle(2);
    model_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule